// File: doc/BRIEF.md
# Card Slot Lifecycle Controller

This block follows the life of a card in each of up to four removable-card slots. A slot moves from empty, to holding a card, to powered, to fully set up, and back to empty when the card is pulled out. Socket hardware supplies a live card-present level for each slot and two event bits per slot: card change and power change. Each cycle the block takes at most one pending event, acknowledges it with a one-cycle pulse, and turns it into a lifecycle message. Software can add messages through a single request port. It can ask for an eject, ask for an insert, or report that setup has finished.

No message changes a slot state directly. Every message goes into a small FIFO first. The FIFO releases one message per cycle, oldest first, and that message is applied to the target slot's state machine. Two problems are reported with one-cycle flags. An illegal state/message pair raises a flag that carries the slot number. A message that finds the FIFO full is dropped and raises an overflow flag.

Top module: `card_slot_lifecycle`

## Requirements
- R1: After a synchronous active-high reset, every slot is Empty, the FIFO is empty, and `badMsg` and `queueOverflow` are low.
- R2: Slot state codes on `slotState[2s+1:2s]` are Empty=0, Full=1, Powered=2, Configured=3. Message codes are Detected=0, Powered=1, Ejected=2, Configured=3. The legal forward steps are Empty with Detected to Full, Full with Powered to Powered, and Powered with Configured to Configured.
- R3: An Ejected message sets a slot that is Full, Powered or Configured back to Empty.
- R4: Any other state/message pair leaves every slot unchanged. In the cycle after it is applied, `badMsg` is high for one cycle and `badSlot` gives the slot index.
- R5: Each cycle, only the lowest-numbered slot with a pending event bit is served. A card-change event is served before a power-change event. The served bit, and only that bit, is acknowledged by a pulse on `ackChg` or `ackPwr` in the same cycle.
- R6: A card-change event is decoded from the live `slotPresent` bit. If a card is present, it posts Detected. If no card is present and the slot's current state is not Empty, it posts Ejected. If no card is present and the slot is Empty, it posts nothing.
- R7: A power-change event posts Powered.
- R8: `swReqKind` values are 0 = insert, 1 = eject, 2 = setup done, 3 = no effect. Insert posts Detected only when the addressed slot shows a card. Eject posts Ejected. Setup done posts Configured. A request addressed to a slot index at or above the slot count is ignored.
- R9: The FIFO pops at most one message per cycle, oldest first. A message pushed at clock edge k is applied no earlier than edge k+1.
- R10: When an event message and a software message are both produced in one cycle, the event message enters the FIFO first.
- R11: The FIFO holds 8 entries. Room is judged on the occupancy at the start of the cycle, and the event message claims it first. A message that finds no room is dropped, and `queueOverflow` is high for the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slotPresent | input | NUM_SLOTS | Live card-present level per slot |
| chgEvent | input | NUM_SLOTS | Pending card-change event per slot |
| pwrEvent | input | NUM_SLOTS | Pending power-change event per slot |
| swReqValid | input | 1 | Software request strobe |
| swReqKind | input | 2 | Request kind: 0 insert, 1 eject, 2 setup done, 3 none |
| swReqSlot | input | 2 | Slot addressed by the software request |
| slotState | output | 2*NUM_SLOTS | Current state code of each slot |
| ackChg | output | NUM_SLOTS | Acknowledge pulse for a served card-change event |
| ackPwr | output | NUM_SLOTS | Acknowledge pulse for a served power-change event |
| badMsg | output | 1 | Illegal message was applied in the previous cycle |
| badSlot | output | 2 | Slot of the latest popped message |
| queueOverflow | output | 1 | A message was dropped at the previous edge |

## Verification
The bench builds the block with four slots and an eight-entry FIFO. Four slots fill the 2-bit slot field, so the lowest-first event priority is tested across every index. Eight entries is shallow enough that a burst of paired event and software messages fills the FIFO within a few cycles and reaches the drop path. The burst is mixed with random event, presence and request traffic, which drives every slot through its full lifecycle, ejects from every non-empty state, and produces illegal pairs.

// File: rtl/card_slot_pkg.sv
package card_slot_pkg;
  localparam int SLOT_W = 2;
  localparam int MAX_SLOTS = 4;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0, ST_FULL = 2'd1, ST_POWERED = 2'd2, ST_CONFIGURED = 2'd3
  } slotState_e;

  typedef enum logic [1:0] {
    MSG_DETECTED = 2'd0, MSG_POWERED = 2'd1, MSG_EJECTED = 2'd2, MSG_CONFIGURED = 2'd3
  } slotMsg_e;

  typedef enum logic [1:0] {
    REQ_INSERT = 2'd0, REQ_EJECT = 2'd1, REQ_SETUP_DONE = 2'd2, REQ_NONE = 2'd3
  } swReq_e;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    slotMsg_e          msg;
  } queueEntry_t;

  typedef struct packed {
    logic        pushA;
    queueEntry_t entryA;
    logic        pushB;
    queueEntry_t entryB;
    logic        pop;
  } queueStrobe_t;
endpackage

// File: rtl/slot_lifecycle_queue.sv
module slot_lifecycle_queue
  import card_slot_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  queueStrobe_t strobe,
  output queueEntry_t  headEntry,
  output logic         queueEmpty,
  output logic         overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  queueEntry_t        mem [DEPTH];
  logic [PTR_W-1:0]   rdPtr, wrPtr, wrPtrB;
  logic [CNT_W-1:0]   count;
  logic               acceptA, acceptB;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    acceptA = strobe.pushA && (count < CNT_W'(DEPTH));
    acceptB = strobe.pushB &&
              (({1'b0, count} + (CNT_W+1)'(acceptA)) < (CNT_W+1)'(DEPTH));
    wrPtrB  = acceptA ? bump(wrPtr) : wrPtr;
  end

  always_ff @(posedge clk) begin
    if (acceptA) mem[wrPtr] <= strobe.entryA;
    if (acceptB) mem[wrPtrB] <= strobe.entryB;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      wrPtr    <= acceptB ? bump(wrPtrB) : wrPtrB;
      if (strobe.pop) rdPtr <= bump(rdPtr);
      count    <= count + CNT_W'(acceptA) + CNT_W'(acceptB) - CNT_W'(strobe.pop);
      overflow <= (strobe.pushA && !acceptA) || (strobe.pushB && !acceptB);
    end
  end

  assign headEntry  = mem[rdPtr];
  assign queueEmpty = (count == '0);
endmodule

// File: rtl/slot_lifecycle_ctrl.sv
module slot_lifecycle_ctrl
  import card_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SLOTS-1:0]  slotPresent,
  input  logic [NUM_SLOTS-1:0]  chgEvent,
  input  logic [NUM_SLOTS-1:0]  pwrEvent,
  input  logic                  swReqValid,
  input  logic [1:0]            swReqKind,
  input  logic [SLOT_W-1:0]     swReqSlot,
  input  queueEntry_t           headEntry,
  input  logic                  queueEmpty,
  output queueStrobe_t          strobe,
  output logic [2*NUM_SLOTS-1:0] slotState,
  output logic [NUM_SLOTS-1:0]  ackChg,
  output logic [NUM_SLOTS-1:0]  ackPwr,
  output logic                  badMsg,
  output logic [SLOT_W-1:0]     badSlot
);
  slotState_e stateQ [NUM_SLOTS];

  logic              intHit, intIsChg, intPresent;
  logic [SLOT_W-1:0] intSlot;
  slotState_e        intCur;
  logic              pushA, pushB, swInRange, swPresent;
  slotMsg_e          msgA, msgB;
  slotState_e        headCur, headNext;
  logic [2:0]        stepRes;
  logic              headLegal;

  function automatic logic [2:0] stepState(input slotState_e cur, input slotMsg_e msg);
    logic       ok;
    slotState_e nxt;
    ok  = 1'b0;
    nxt = cur;
    case (msg)
      MSG_DETECTED:   if (cur == ST_EMPTY)   begin ok = 1'b1; nxt = ST_FULL;       end
      MSG_POWERED:    if (cur == ST_FULL)    begin ok = 1'b1; nxt = ST_POWERED;    end
      MSG_CONFIGURED: if (cur == ST_POWERED) begin ok = 1'b1; nxt = ST_CONFIGURED; end
      default:        if (cur != ST_EMPTY)   begin ok = 1'b1; nxt = ST_EMPTY;      end
    endcase
    return {ok, nxt};
  endfunction

  // lowest-numbered slot with a pending event wins; change before power
  always_comb begin
    intHit = 1'b0; intIsChg = 1'b0; intPresent = 1'b0;
    intSlot = '0; intCur = ST_EMPTY;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (chgEvent[i] || pwrEvent[i]) begin
        intHit     = 1'b1;
        intIsChg   = chgEvent[i];
        intPresent = slotPresent[i];
        intSlot    = SLOT_W'(i);
        intCur     = stateQ[i];
      end
    end
    ackChg = (intHit && intIsChg)  ? (NUM_SLOTS'(1) << intSlot) : '0;
    ackPwr = (intHit && !intIsChg) ? (NUM_SLOTS'(1) << intSlot) : '0;
    pushA = 1'b0;
    msgA  = MSG_DETECTED;
    if (intHit) begin
      if (!intIsChg) begin
        pushA = 1'b1; msgA = MSG_POWERED;
      end else if (intPresent) begin
        pushA = 1'b1; msgA = MSG_DETECTED;
      end else if (intCur != ST_EMPTY) begin
        pushA = 1'b1; msgA = MSG_EJECTED;
      end
    end
  end

  always_comb begin
    swInRange = 1'b0;
    swPresent = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (swReqSlot == SLOT_W'(i)) begin
        swInRange = 1'b1;
        swPresent = slotPresent[i];
      end
    end
    pushB = 1'b0;
    msgB  = MSG_DETECTED;
    if (swReqValid && swInRange) begin
      case (swReq_e'(swReqKind))
        REQ_INSERT:     begin pushB = swPresent; msgB = MSG_DETECTED;   end
        REQ_EJECT:      begin pushB = 1'b1;      msgB = MSG_EJECTED;    end
        REQ_SETUP_DONE: begin pushB = 1'b1;      msgB = MSG_CONFIGURED; end
        default:        pushB = 1'b0;
      endcase
    end
  end

  always_comb begin
    strobe.pushA       = pushA;
    strobe.entryA.slot = intSlot;
    strobe.entryA.msg  = msgA;
    strobe.pushB       = pushB;
    strobe.entryB.slot = swReqSlot;
    strobe.entryB.msg  = msgB;
    strobe.pop         = !queueEmpty;
  end

  always_comb begin
    headCur = ST_EMPTY;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (headEntry.slot == SLOT_W'(i)) headCur = stateQ[i];
    stepRes   = stepState(headCur, headEntry.msg);
    headLegal = stepRes[2];
    headNext  = slotState_e'(stepRes[1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) stateQ[i] <= ST_EMPTY;
      badMsg  <= 1'b0;
      badSlot <= '0;
    end else begin
      badMsg <= !queueEmpty && !headLegal;
      if (!queueEmpty) badSlot <= headEntry.slot;
      for (int i = 0; i < NUM_SLOTS; i++)
        if (!queueEmpty && headLegal && headEntry.slot == SLOT_W'(i))
          stateQ[i] <= headNext;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_out
    assign slotState[2*g +: 2] = stateQ[g];
  end
endmodule

// File: rtl/card_slot_lifecycle.sv
module card_slot_lifecycle
  import card_slot_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int QUEUE_DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_SLOTS-1:0]   slotPresent,
  input  logic [NUM_SLOTS-1:0]   chgEvent,
  input  logic [NUM_SLOTS-1:0]   pwrEvent,
  input  logic                   swReqValid,
  input  logic [1:0]             swReqKind,
  input  logic [1:0]             swReqSlot,
  output logic [2*NUM_SLOTS-1:0] slotState,
  output logic [NUM_SLOTS-1:0]   ackChg,
  output logic [NUM_SLOTS-1:0]   ackPwr,
  output logic                   badMsg,
  output logic [1:0]             badSlot,
  output logic                   queueOverflow
);
  queueStrobe_t strobe;
  queueEntry_t  headEntry;
  logic         queueEmpty;

  slot_lifecycle_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk(clk), .rst(rst),
    .slotPresent(slotPresent), .chgEvent(chgEvent), .pwrEvent(pwrEvent),
    .swReqValid(swReqValid), .swReqKind(swReqKind), .swReqSlot(swReqSlot),
    .headEntry(headEntry), .queueEmpty(queueEmpty), .strobe(strobe),
    .slotState(slotState), .ackChg(ackChg), .ackPwr(ackPwr),
    .badMsg(badMsg), .badSlot(badSlot)
  );

  slot_lifecycle_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
    .clk(clk), .rst(rst), .strobe(strobe),
    .headEntry(headEntry), .queueEmpty(queueEmpty), .overflow(queueOverflow)
  );
endmodule

// File: rtl/card_slot_lifecycle_chk.sv
module card_slot_lifecycle_chk #(
  parameter int NUM_SLOTS = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_SLOTS-1:0]   chgEvent,
  input logic [NUM_SLOTS-1:0]   pwrEvent,
  input logic [NUM_SLOTS-1:0]   ackChg,
  input logic [NUM_SLOTS-1:0]   ackPwr,
  input logic [2*NUM_SLOTS-1:0] slotState,
  input logic                   badMsg,
  input logic                   queueOverflow
);
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (slotState == '0 && !badMsg && !queueOverflow)); // R1

  AST_BAD_FREEZES: assert property (@(posedge clk) disable iff (rst)
    badMsg |-> slotState == $past(slotState)); // R4

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ackChg, ackPwr})); // R5

  AST_ACK_CHG_PENDING: assert property (@(posedge clk) disable iff (rst)
    (ackChg & ~chgEvent) == '0); // R5

  AST_ACK_PWR_PENDING: assert property (@(posedge clk) disable iff (rst)
    (ackPwr & ~pwrEvent) == '0); // R5

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    AST_STEP_FORWARD: assert property (@(posedge clk) disable iff (rst)
      (slotState[2*s +: 2] != $past(slotState[2*s +: 2]) && slotState[2*s +: 2] != 2'd0)
      |-> slotState[2*s +: 2] == $past(slotState[2*s +: 2]) + 2'd1); // R2
  end
endmodule

bind card_slot_lifecycle card_slot_lifecycle_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst(rst), .chgEvent(chgEvent), .pwrEvent(pwrEvent),
  .ackChg(ackChg), .ackPwr(ackPwr), .slotState(slotState),
  .badMsg(badMsg), .queueOverflow(queueOverflow)
);

// File: tb/sim_card_slot_lifecycle.sv
module sim_card_slot_lifecycle;
  localparam int NS = 4;
  localparam int QD = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [NS-1:0]   slotPresent = '0, chgEvent = '0, pwrEvent = '0;
  logic            swReqValid = 1'b0;
  logic [1:0]      swReqKind = '0, swReqSlot = '0;
  logic [2*NS-1:0] slotState;
  logic [NS-1:0]   ackChg, ackPwr;
  logic            badMsg, queueOverflow;
  logic [1:0]      badSlot;

  card_slot_lifecycle #(.NUM_SLOTS(NS), .QUEUE_DEPTH(QD)) u0 (
    .clk(clk), .rst(rst), .slotPresent(slotPresent), .chgEvent(chgEvent),
    .pwrEvent(pwrEvent), .swReqValid(swReqValid), .swReqKind(swReqKind),
    .swReqSlot(swReqSlot), .slotState(slotState), .ackChg(ackChg),
    .ackPwr(ackPwr), .badMsg(badMsg), .badSlot(badSlot),
    .queueOverflow(queueOverflow)
  );

  int nChecks = 0;
  int nErr = 0;
  bit finished = 1'b0;
  int mState [NS];
  int qSlot [$];
  int qMsg [$];
  bit [NS-1:0] chgPend = '0, pwrPend = '0, presV = '0;
  bit swV = 1'b0;
  int swK = 0, swS = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected transition per R2, R3, R4
  function automatic int nextOf(input int st, input int msg, output bit ok);
    ok = 1'b1;
    if (msg == 2 && st != 0) return 0;
    if (msg == 0 && st == 0) return 1;
    if (msg == 1 && st == 1) return 2;
    if (msg == 3 && st == 2) return 3;
    ok = 1'b0;
    return st;
  endfunction

  task automatic cycle();
    int pick, mA, mB, cnt, s, m, ns, acc, expAckC, expAckP, expBadSlot;
    bit hasA, hasB, okT, expBad, expOvf;
    @(negedge clk);
    slotPresent = presV; chgEvent = chgPend; pwrEvent = pwrPend;
    swReqValid = swV; swReqKind = 2'(swK); swReqSlot = 2'(swS);
    pick = -1;
    for (int i = NS - 1; i >= 0; i--) if (chgPend[i] || pwrPend[i]) pick = i;
    expAckC = 0; expAckP = 0; hasA = 1'b0; mA = 0;
    if (pick >= 0) begin
      if (chgPend[pick]) begin
        expAckC = 1 << pick;
        if (presV[pick]) begin hasA = 1'b1; mA = 0; end
        else if (mState[pick] != 0) begin hasA = 1'b1; mA = 2; end
      end else begin
        expAckP = 1 << pick; hasA = 1'b1; mA = 1;
      end
    end
    hasB = 1'b0; mB = 0;
    if (swV) begin
      case (swK)
        0: if (presV[swS]) begin hasB = 1'b1; mB = 0; end
        1: begin hasB = 1'b1; mB = 2; end
        2: begin hasB = 1'b1; mB = 3; end
        default: hasB = 1'b0;
      endcase
    end
    #1;
    chk("R5 ackChg", int'(ackChg), expAckC);
    chk("R5 ackPwr", int'(ackPwr), expAckP);
    cnt = qSlot.size();
    expBad = 1'b0; expBadSlot = 0;
    if (cnt > 0) begin
      s = qSlot.pop_front();
      m = qMsg.pop_front();
      ns = nextOf(mState[s], m, okT);
      if (okT) mState[s] = ns;
      else begin expBad = 1'b1; expBadSlot = s; end
    end
    acc = cnt; expOvf = 1'b0;
    if (hasA) begin
      if (acc < QD) begin qSlot.push_back(pick); qMsg.push_back(mA); acc++; end
      else expOvf = 1'b1;
    end
    if (hasB) begin
      if (acc < QD) begin qSlot.push_back(swS); qMsg.push_back(mB); acc++; end
      else expOvf = 1'b1;
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < NS; i++)
      chk("R2 R3 R6 R7 R8 R9 R10 slot state", int'(slotState[2*i +: 2]), mState[i]);
    chk("R4 badMsg", int'(badMsg), int'(expBad));
    if (expBad) chk("R4 badSlot", int'(badSlot), expBadSlot);
    chk("R11 queueOverflow", int'(queueOverflow), int'(expOvf));
    chgPend = chgPend & ~NS'(expAckC);
    pwrPend = pwrPend & ~NS'(expAckP);
    swV = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  initial begin
    int sawOvf;
    void'($urandom(32'd4242));
    for (int i = 0; i < NS; i++) mState[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 slotState after reset", int'(slotState), 0);
    chk("R1 badMsg after reset", int'(badMsg), 0);
    chk("R1 queueOverflow after reset", int'(queueOverflow), 0);

    // R4: eject on an Empty slot is illegal
    swV = 1'b1; swK = 1; swS = 0; cycle();
    cycle();
    // R8: kind 3 has no effect
    swV = 1'b1; swK = 3; swS = 1; cycle();
    idle(2);
    chk("R8 reserved kind leaves slot 1 Empty", int'(slotState[3:2]), 0);

    // R2: full lifecycle on slot 2
    presV[2] = 1'b1; chgPend[2] = 1'b1; cycle();
    pwrPend[2] = 1'b1; cycle();
    swV = 1'b1; swK = 2; swS = 2; cycle();
    idle(3);
    chk("R2 slot 2 Configured", int'(slotState[5:4]), 3);

    // R3: card removed from Configured slot
    presV[2] = 1'b0; chgPend[2] = 1'b1; cycle();
    idle(2);
    chk("R3 slot 2 back to Empty", int'(slotState[5:4]), 0);

    // R10: event Detected and software eject on slot 1 in the same cycle
    presV[1] = 1'b1; chgPend[1] = 1'b1; swV = 1'b1; swK = 1; swS = 1; cycle();
    idle(3);
    chk("R10 slot 1 Empty after Detected then Ejected", int'(slotState[3:2]), 0);

    // R6: change with no card on an Empty slot posts nothing
    presV[3] = 1'b0; chgPend[3] = 1'b1; cycle();
    idle(2);
    chk("R6 slot 3 stays Empty", int'(slotState[7:6]), 0);

    // R5: simultaneous events served lowest slot first
    chgPend = '1; pwrPend = '1; presV = '1;
    idle(10);

    // R11: burst of two messages per cycle
    sawOvf = 0;
    for (int k = 0; k < 14; k++) begin
      pwrPend = '1; swV = 1'b1; swK = 0; swS = k % NS;
      cycle();
      if (queueOverflow) sawOvf++;
    end
    chk("R11 overflow reached during burst", int'(sawOvf > 0), 1);
    chgPend = '0; pwrPend = '0;
    idle(20);

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < NS; i++) begin
        if ($urandom % 8 == 0) chgPend[i] = 1'b1;
        if ($urandom % 8 == 0) pwrPend[i] = 1'b1;
        if ($urandom % 16 == 0) presV[i] = ~presV[i];
      end
      swV = ($urandom % 2) == 0;
      swK = int'($urandom % 4);
      swS = int'($urandom % 4);
      cycle();
    end
    idle(12);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog R9 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule